// File: doc/BRIEF.md
# Indirect-Operand AND Execution Unit

This unit executes a family of eight logical-AND instructions for a small processor datapath with 4-bit data. The source operand is a data-memory word. Its address comes from one of two 16-bit index registers, X or Y. The destination is one of two 4-bit accumulators, A or B. An instruction presented with `instr_valid` finishes in a single clock cycle:

- During the cycle, the unit drives a read address and strobe, and the memory returns the word combinationally.
- At the closing edge, the unit writes the masked result back to the accumulator.
- If the instruction is a post-increment form, the unit steps the named index register.
- The unit updates the zero flag.

A one-shot extension prefix can be loaded ahead of an instruction. It holds an 8-bit value, and the E flag shows that it is pending.

A small two-state machine tracks the prefix:

- `ST_PLAIN` means no prefix is pending.
- A prefix load takes the machine from `ST_PLAIN` to `ST_ARMED`. This transition is "arm".
- A prefix load while in `ST_ARMED` replaces the stored value and stays in `ST_ARMED`. This transition is "re-arm".
- Any handled instruction returns the machine to `ST_PLAIN`. This transition is "consume".

While the machine is in `ST_ARMED`, a non-incrementing instruction reads from a fixed 256-word page instead of the index register. The page sits at the bottom of memory when X is named and at the top when Y is named. Post-increment forms ignore the pending prefix for addressing, but they still consume it.

The register-load port is there so the surrounding datapath can set the accumulators, the index registers and the I/C/Z flags. A code outside the family raises `unhandled` for the sequencer and has no other effect.

Top module: `and_exec_unit`

## Requirements
- R1: Codes 0x1A60 to 0x1A67 are handled. Bit 2 picks the accumulator (0 = A, 1 = B), bit 1 picks the index register (0 = X, 1 = Y), and bit 0 picks post-increment (1 = increment). The bitwise AND of the memory word and the picked accumulator is written back to that accumulator at the end of the cycle. The other accumulator is unchanged.
- R2: After a handled instruction, Z (bit 0 of `flags`) is 1 exactly when the 4-bit result is zero. I (bit 2) and C (bit 1) keep their values.
- R3: A prefix load sets E (bit 3 of `flags`) and stores the 8-bit value. Every handled instruction clears E, whether or not the extension was used.
- R4: A post-increment form adds one to the picked index register, wrapping 0xFFFF to 0x0000, and leaves the other index register unchanged. The index step never alters any flag. A non-incrementing form leaves both index registers unchanged.
- R5: With no prefix pending, a handled instruction drives `mem_rd_en` high and `mem_addr` equal to the picked index register during its cycle. When `instr_valid` is low, `mem_rd_en` is low.
- R6: With a prefix pending and a non-incrementing form, the address is 0x0000 plus the prefix value when X is named. It is 0xFF00 plus the prefix value when Y is named.
- R7: A post-increment form uses the index register as its address even when a prefix is pending.
- R8: A valid code outside 0x1A60 to 0x1A67 raises `unhandled` in the same cycle. It also holds `mem_rd_en` low and `mem_addr` at zero. It changes no register or flag, including a pending E.
- R9: After reset, A, B, X, Y and all flags are zero, and `mem_rd_en` and `unhandled` are low.
- R10: The register-load port writes a register chosen by `reg_wr_sel`: 0 = A, 1 = B, 2 = X, 3 = Y, 4 = I/C/Z from `reg_wr_data[2:0]`. Other selector values are ignored. In any one cycle, a valid instruction wins over a prefix load, and a prefix load wins over a register load. A lower-priority request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_code | input | 13 | Instruction code |
| ext_load | input | 1 | Load the extension prefix |
| ext_value | input | 8 | Prefix page offset |
| reg_wr_en | input | 1 | Register-load strobe |
| reg_wr_sel | input | 3 | Register-load target (0 A, 1 B, 2 X, 3 Y, 4 flags) |
| reg_wr_data | input | 16 | Register-load data |
| mem_rd_en | output | 1 | Data-memory read strobe |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 4 | Data-memory read word, same cycle |
| acc_a | output | 4 | Accumulator A |
| acc_b | output | 4 | Accumulator B |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| flags | output | 4 | {E, I, C, Z} |
| unhandled | output | 1 | Valid code outside the family |

## Verification
The bench checks how the prefix interacts with the addressing modes:

- It confirms that a post-increment form keeps the index address under a pending prefix. A design that applied the page would read the wrong word.
- It confirms that the same post-increment form still clears E. A design that left E set would extend a later unrelated instruction.
- It issues illegal codes between a prefix and its user. A design that consumed E on an unhandled code would lose the page.

It also covers the remaining corner cases:

- An increment from 0xFFFF must wrap to zero, with the flags untouched.
- A result of zero must set Z while I and C stay put.
- A cycle that combines an instruction, a prefix load and a register load must let the instruction win. A design with the wrong priority would overwrite the result or arm a stray prefix.

// File: rtl/and_exec_pkg.sv
package and_exec_pkg;

    typedef enum logic [0:0] {
        ST_PLAIN = 1'b0,
        ST_ARMED = 1'b1
    } pfx_state_e;

    typedef enum logic [2:0] {
        RSEL_A     = 3'd0,
        RSEL_B     = 3'd1,
        RSEL_X     = 3'd2,
        RSEL_Y     = 3'd3,
        RSEL_FLAGS = 3'd4
    } rsel_e;

    typedef struct packed {
        logic legal;
        logic acc_b;
        logic idx_y;
        logic post_inc;
    } dec_t;

    localparam int FLG_E = 3;
    localparam int FLG_I = 2;
    localparam int FLG_C = 1;
    localparam int FLG_Z = 0;

endpackage

// File: rtl/and_decode.sv
module and_decode
    import and_exec_pkg::*;
#(
    parameter int               OPC_W    = 13,
    parameter logic [OPC_W-1:0] OPC_BASE = 13'h1A60
) (
    input  logic [OPC_W-1:0] code,
    output dec_t             dec
);
    localparam int FAM_W = OPC_W - 3;
    localparam logic [FAM_W-1:0] FAMILY = OPC_BASE[OPC_W-1:3];

    always_comb begin
        dec.legal    = (code[OPC_W-1:3] == FAMILY);
        dec.acc_b    = code[2];
        dec.idx_y    = code[1];
        dec.post_inc = code[0];
    end
endmodule

// File: rtl/ext_prefix_fsm.sv
module ext_prefix_fsm
    import and_exec_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [EXT_W-1:0] load_val,
    input  logic             consume,
    output logic             active,
    output logic [EXT_W-1:0] ext_val
);
    pfx_state_e       state_q, state_d;
    logic [EXT_W-1:0] val_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLAIN: begin
                if (load)
                    state_d = ST_ARMED;   // arm
            end
            ST_ARMED: begin
                if (consume)
                    state_d = ST_PLAIN;   // consume
                else if (load)
                    state_d = ST_ARMED;   // re-arm
            end
            default: state_d = ST_PLAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLAIN;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load && !consume)
                val_q <= load_val;
        end
    end

    always_comb begin
        active  = (state_q == ST_ARMED);
        ext_val = val_q;
    end

    p_consume_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !active);
    p_load_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !consume) |=> (active && ext_val == $past(load_val)));
endmodule

// File: rtl/and_agu.sv
module and_agu
    import and_exec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic              go,
    input  dec_t              dec,
    input  logic              ext_active,
    input  logic [EXT_W-1:0]  ext_val,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] next_idx
);
    localparam int PAGE_W = ADDR_W - EXT_W;

    logic [ADDR_W-1:0] ext_addr;
    logic [ADDR_W-1:0] base;
    logic              use_ext;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign ext_addr = {(dec.idx_y ? {PAGE_W{1'b1}} : {PAGE_W{1'b0}}), ext_val};
        end else begin : g_flat
            assign ext_addr = ext_val[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        base     = dec.idx_y ? idx_y : idx_x;
        use_ext  = ext_active && !dec.post_inc;
        rd_en    = go;
        addr     = '0;
        if (go)
            addr = use_ext ? ext_addr : base;
        next_idx = base + 1'b1;
    end
endmodule

// File: rtl/and_regs.sv
module and_regs
    import and_exec_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] next_idx,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_a,
    output logic [DATA_W-1:0] acc_b,
    output logic [ADDR_W-1:0] idx_x,
    output logic [ADDR_W-1:0] idx_y,
    output logic              flag_i,
    output logic              flag_c,
    output logic              flag_z
);
    logic [DATA_W-1:0] acc_q [2];
    logic [ADDR_W-1:0] idx_q [2];
    logic [DATA_W-1:0] sel_acc;
    logic [DATA_W-1:0] result;
    rsel_e             sel;

    always_comb begin
        sel     = rsel_e'(wr_sel);
        sel_acc = dec.acc_b ? acc_q[1] : acc_q[0];
        result  = sel_acc & rdata;
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_acc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    acc_q[g] <= '0;
                else if (exec) begin
                    if (dec.acc_b == 1'(g))
                        acc_q[g] <= result;
                end else if (wr_en && wr_sel == 3'(g))
                    acc_q[g] <= wr_data[DATA_W-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    idx_q[g] <= '0;
                else if (exec) begin
                    if (dec.post_inc && dec.idx_y == 1'(g))
                        idx_q[g] <= next_idx;
                end else if (wr_en && wr_sel == 3'(g + 2))
                    idx_q[g] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_i <= 1'b0;
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else if (exec) begin
            flag_z <= (result == '0);
        end else if (wr_en) begin
            unique case (sel)
                RSEL_FLAGS: begin
                    flag_i <= wr_data[FLG_I];
                    flag_c <= wr_data[FLG_C];
                    flag_z <= wr_data[FLG_Z];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        acc_a = acc_q[0];
        acc_b = acc_q[1];
        idx_x = idx_q[0];
        idx_y = idx_q[1];
    end

    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (flag_z == ($past(dec.acc_b) ? (acc_b == '0) : (acc_a == '0))));
    p_ic_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> ($stable(flag_i) && $stable(flag_c)));
    p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.post_inc && !dec.idx_y) |=> (idx_x == ADDR_W'($past(idx_x) + 1'b1) && $stable(idx_y)));
    p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dec.post_inc) |=> ($stable(idx_x) && $stable(idx_y)));
    p_other_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.acc_b) |=> $stable(acc_a));
endmodule

// File: rtl/and_exec_unit.sv
module and_exec_unit
    import and_exec_pkg::*;
#(
    parameter int               DATA_W   = 4,
    parameter int               ADDR_W   = 16,
    parameter int               EXT_W    = 8,
    parameter int               OPC_W    = 13,
    parameter logic [OPC_W-1:0] OPC_BASE = 13'h1A60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  instr_code,
    input  logic              ext_load,
    input  logic [EXT_W-1:0]  ext_value,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_a,
    output logic [DATA_W-1:0] acc_b,
    output logic [ADDR_W-1:0] idx_x,
    output logic [ADDR_W-1:0] idx_y,
    output logic [3:0]        flags,
    output logic              unhandled
);
    dec_t              dec;
    logic              exec;
    logic              pfx_load;
    logic              wr_ok;
    logic              ext_active;
    logic [EXT_W-1:0]  ext_val;
    logic [ADDR_W-1:0] next_idx;
    logic              flag_i, flag_c, flag_z;

    and_decode #(.OPC_W(OPC_W), .OPC_BASE(OPC_BASE)) u_dec (
        .code (instr_code),
        .dec  (dec)
    );

    always_comb begin
        exec      = instr_valid && dec.legal;
        unhandled = instr_valid && !dec.legal;
        pfx_load  = ext_load && !instr_valid;
        wr_ok     = reg_wr_en && !instr_valid && !ext_load;
    end

    ext_prefix_fsm #(.EXT_W(EXT_W)) u_pfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pfx_load),
        .load_val (ext_value),
        .consume  (exec),
        .active   (ext_active),
        .ext_val  (ext_val)
    );

    and_agu #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_agu (
        .go         (exec),
        .dec        (dec),
        .ext_active (ext_active),
        .ext_val    (ext_val),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .rd_en      (mem_rd_en),
        .addr       (mem_addr),
        .next_idx   (next_idx)
    );

    and_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec),
        .dec      (dec),
        .rdata    (mem_rdata),
        .next_idx (next_idx),
        .wr_en    (wr_ok),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .flag_i   (flag_i),
        .flag_c   (flag_c),
        .flag_z   (flag_z)
    );

    always_comb begin
        flags        = '0;
        flags[FLG_E] = ext_active;
        flags[FLG_I] = flag_i;
        flags[FLG_C] = flag_c;
        flags[FLG_Z] = flag_z;
    end

    p_unhandled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> (!mem_rd_en && mem_addr == '0));
    p_unhandled_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |=> ($stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y) && $stable(flags)));
    p_idle_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !mem_rd_en);
    p_page_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && flags[FLG_E] && !dec.post_inc) |-> (mem_addr[EXT_W-1:0] == ext_val));
    p_postinc_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && dec.post_inc && !dec.idx_y) |-> (mem_addr == idx_x));
endmodule

// File: tb/tb_and_exec_unit.sv
`timescale 1ns/1ps
module tb_and_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [12:0] instr_code = '0;
    logic        ext_load = 1'b0;
    logic [7:0]  ext_value = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [3:0]  mem_rdata;
    logic [3:0]  acc_a, acc_b;
    logic [15:0] idx_x, idx_y;
    logic [3:0]  flags;
    logic        unhandled;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0]  mA, mB;
    logic [15:0] mX, mY;
    logic        mE, mI, mC, mZ;
    logic [7:0]  mExt;

    always #4 clk = ~clk;

    and_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_code(instr_code),
        .ext_load(ext_load), .ext_value(ext_value), .reg_wr_en(reg_wr_en),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc_a(acc_a), .acc_b(acc_b),
        .idx_x(idx_x), .idx_y(idx_y), .flags(flags), .unhandled(unhandled)
    );

    function automatic logic [3:0] memf(input logic [15:0] a);
        return a[3:0] ^ a[7:4] ^ a[15:12];
    endfunction

    assign mem_rdata = memf(mem_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " acc_a"}, 32'(acc_a), 32'(mA));
        chk({req, " acc_b"}, 32'(acc_b), 32'(mB));
        chk({req, " idx_x"}, 32'(idx_x), 32'(mX));
        chk({req, " idx_y"}, 32'(idx_y), 32'(mY));
        chk({req, " flags"}, 32'(flags), 32'({mE, mI, mC, mZ}));
    endtask

    task automatic load_reg(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        case (sel)
            3'd0: mA = data[3:0];
            3'd1: mB = data[3:0];
            3'd2: mX = data;
            3'd3: mY = data;
            3'd4: begin mI = data[2]; mC = data[1]; mZ = data[0]; end
            default: ;
        endcase
    endtask

    task automatic prefix(input logic [7:0] v);
        @(negedge clk);
        ext_load = 1'b1; ext_value = v;
        @(posedge clk); #1;
        ext_load = 1'b0;
        mE = 1'b1; mExt = v;
        chk("R3 prefix sets E", 32'(flags[3]), 32'd1);
    endtask

    task automatic run_instr(input logic [12:0] code, input string req,
                             input bit extra_wr = 0, input bit extra_pfx = 0);
        logic        legal, sb, sy, inc;
        logic [15:0] idx, ea;
        logic [3:0]  res;
        @(negedge clk);
        instr_valid = 1'b1; instr_code = code;
        if (extra_wr)  begin reg_wr_en = 1'b1; reg_wr_sel = 3'd0; reg_wr_data = 16'h000F; end
        if (extra_pfx) begin ext_load = 1'b1; ext_value = 8'hEE; end
        #1;
        legal = (code[12:3] == 10'h34C);
        sb = code[2]; sy = code[1]; inc = code[0];
        if (legal) begin
            idx = sy ? mY : mX;
            ea  = (mE && !inc) ? {(sy ? 8'hFF : 8'h00), mExt} : idx;
            chk({req, " rd_en"}, 32'(mem_rd_en), 32'd1);
            chk({req, " addr"}, 32'(mem_addr), 32'(ea));
            chk({req, " unhandled"}, 32'(unhandled), 32'd0);
            res = (sb ? mB : mA) & memf(ea);
            if (sb) mB = res; else mA = res;
            mZ = (res == 4'd0);
            mE = 1'b0;
            if (inc) begin
                if (sy) mY = mY + 16'd1; else mX = mX + 16'd1;
            end
        end else begin
            chk({req, " unhandled"}, 32'(unhandled), 32'd1);
            chk({req, " rd_en"}, 32'(mem_rd_en), 32'd0);
            chk({req, " addr"}, 32'(mem_addr), 32'd0);
        end
        @(posedge clk); #1;
        instr_valid = 1'b0; reg_wr_en = 1'b0; ext_load = 1'b0;
        chk_state(req);
    endtask

    task automatic t_reset();
        chk_state("R9 reset");
        chk("R9 rd_en", 32'(mem_rd_en), 32'd0);
        chk("R9 unhandled", 32'(unhandled), 32'd0);
    endtask

    task automatic t_plain();
        load_reg(3'd0, 16'h000B);
        load_reg(3'd1, 16'h0006);
        load_reg(3'd2, 16'h1234);
        load_reg(3'd3, 16'h00F0);
        load_reg(3'd4, 16'h0006);
        load_reg(3'd7, 16'hFFFF);
        chk_state("R10 loads and ignored selector");
        chk("R5 idle rd_en", 32'(mem_rd_en), 32'd0);
        run_instr(13'h1A60, "R1 R5 AND A,[X]");
        run_instr(13'h1A66, "R1 R5 AND B,[Y]");
        load_reg(3'd0, 16'h000F);
        run_instr(13'h1A62, "R1 AND A,[Y]");
        load_reg(3'd1, 16'h000F);
        run_instr(13'h1A64, "R1 AND B,[X]");
    endtask

    task automatic t_zero();
        load_reg(3'd4, 16'h0004);
        load_reg(3'd0, 16'h0005);
        load_reg(3'd2, 16'h000A);
        run_instr(13'h1A60, "R2 zero result");
        chk("R2 Z set", 32'(flags[0]), 32'd1);
        load_reg(3'd0, 16'h000F);
        run_instr(13'h1A60, "R2 nonzero result");
    endtask

    task automatic t_postinc();
        load_reg(3'd4, 16'h0002);
        load_reg(3'd2, 16'hFFFF);
        run_instr(13'h1A61, "R4 X wrap");
        chk("R4 X wrapped", 32'(idx_x), 32'd0);
        load_reg(3'd3, 16'h1000);
        run_instr(13'h1A67, "R4 Y step");
        run_instr(13'h1A65, "R4 X step B");
    endtask

    task automatic t_ext();
        load_reg(3'd2, 16'h4321);
        load_reg(3'd3, 16'h2222);
        prefix(8'h3C);
        run_instr(13'h1A60, "R6 page X");
        chk("R3 E consumed", 32'(flags[3]), 32'd0);
        run_instr(13'h1A60, "R3 R5 after consume");
        prefix(8'h11);
        prefix(8'h81);
        run_instr(13'h1A66, "R6 page Y re-armed");
    endtask

    task automatic t_ext_postinc();
        load_reg(3'd3, 16'h7ABC);
        prefix(8'h55);
        run_instr(13'h1A63, "R7 post-inc ignores prefix");
        chk("R7 E cleared", 32'(flags[3]), 32'd0);
    endtask

    task automatic t_illegal();
        load_reg(3'd2, 16'h0999);
        prefix(8'h12);
        run_instr(13'h1A68, "R8 code above");
        run_instr(13'h1A5F, "R8 code below");
        run_instr(13'h0000, "R8 zero code");
        chk("R8 E kept", 32'(flags[3]), 32'd1);
        load_reg(3'd1, 16'h0007);
        run_instr(13'h1A64, "R8 R6 prefix survives");
    endtask

    task automatic t_priority();
        load_reg(3'd0, 16'h0003);
        load_reg(3'd2, 16'h0F0F);
        run_instr(13'h1A60, "R10 instr wins", 1'b1, 1'b1);
        chk("R10 no stray prefix", 32'(flags[3]), 32'd0);
        @(negedge clk);
        ext_load = 1'b1; ext_value = 8'h44;
        reg_wr_en = 1'b1; reg_wr_sel = 3'd1; reg_wr_data = 16'h0009;
        @(posedge clk); #1;
        ext_load = 1'b0; reg_wr_en = 1'b0;
        mE = 1'b1; mExt = 8'h44;
        chk_state("R10 prefix beats load");
    endtask

    initial begin
        mA = '0; mB = '0; mX = '0; mY = '0;
        mE = 0; mI = 0; mC = 0; mZ = 0; mExt = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_plain();
        t_zero();
        t_postinc();
        t_ext();
        t_ext_postinc();
        t_illegal();
        t_priority();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule